// File: doc/BRIEF.md
# Flash Command Interpreter

This block is a synchronous, clock-counted model of the control logic inside a byte-wide NOR flash that is divided into uniform 128-byte sectors. The host presents decoded single-cycle write strobes (`wr_en` with `addr` and `wdata`) and read strobes (`rd_en` with `addr`). Alterations to the array are guarded by keyed command sequences. The engine follows these sequences through a named state machine. It starts a byte program, a sector erase or a whole-array erase. It also enters and leaves an identification mode in which reads return fixed codes.

After the engine accepts an operation, it reports busy for a set number of clocks. During that window it ignores every write. A read in that window returns two status bits in place of array data: an inverted-data poll bit on bit 7 and a flip-per-read bit on bit 6. Programming can only clear bits, so a byte must be erased to FFh before it can take an arbitrary value. A synchronous active-low reset drops any partial sequence, leaves identification mode and cancels a running operation. It does not touch the array contents.

States: `S_IDLE` (normal reads), `S_KEY1` (first key seen), `S_KEY2` (both keys seen), `S_PROG_ARM` (awaiting target byte), `S_ERA_ARM` (erase announced), `S_ERA_KEY1` and `S_ERA_KEY2` (second key pair for erase), and `S_BUSY` (operation running). Transitions:
- IDLE to KEY1 on AAh@555h.
- KEY1 to KEY2 on 55h@2AAh.
- From KEY2 on a write at 555h:
  - A0h goes to PROG_ARM.
  - 80h goes to ERA_ARM.
  - 90h sets ID mode and goes to IDLE.
  - F0h clears ID mode and goes to IDLE.
- PROG_ARM to BUSY on any write.
- ERA_ARM to ERA_KEY1 on AAh@555h.
- ERA_KEY1 to ERA_KEY2 on 55h@2AAh.
- From ERA_KEY2:
  - 20h at any address goes to BUSY and erases that sector.
  - 10h@555h goes to BUSY and erases the whole array.
- BUSY to IDLE when the timer expires.
- Any other write in a non-busy state goes to IDLE.

Top module: `nor_cmd_engine`

## Requirements
- R1: A synchronous reset (rst_n low at a clock edge) leaves busy at 0, rdata at 00h, identification mode off and no partial sequence. A sequence begun before reset does not continue after it, and a running operation stops at once.
- R2: Command addresses are matched only on address bits 14..0; bits above 14 may hold any value.
- R3: The write series AAh@555h, 55h@2AAh, A0h@555h, then (target address, data) starts a byte program. The stored byte becomes the old byte AND the data, so bits only go from 1 to 0. Busy rises only in the cycle after an accepted write.
- R4: The write series AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh, then 20h at any address sets all 128 bytes of that address's sector to FFh. The sector is array address bits above bit 6. Bytes in other sectors are unchanged.
- R5: The same first five writes followed by 10h@555h set every array byte to FFh.
- R6: A write that does not match the expected next step drops the sequence back to idle. Later writes must restart from the first key.
- R7: While busy, every write is ignored. This includes program, erase, identification entry and identification exit.
- R8: A read while busy returns, on bit 7, the inverse of bit 7 of the programmed data for a program, or 0 for an erase. Bits 5..0 read 0.
- R9: Bit 6 of successive busy reads alternates, starting at 1 on the first read after the operation starts. After completion, reads return true array data.
- R10: Busy stays high for PROG_CYC clocks after a program starts, SECT_CYC after a sector erase and CHIP_CYC after a whole-array erase.
- R11: The write series AAh@555h, 55h@2AAh, 90h@555h enters identification mode. A non-busy read there returns BFh when address bit 0 is 0 and DEV_CODE when it is 1.
- R12: Identification mode is left by a single F0h write at any address while no sequence is in progress, or by AAh@555h, 55h@2AAh, F0h@555h.
- R13: rdata changes only at a clock edge where rd_en is sampled high (or at reset), and it holds otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | One-cycle write strobe |
| rd_en | input | 1 | One-cycle read strobe |
| addr | input | ADDR_W | Byte address for reads and writes |
| wdata | input | 8 | Write data or command code |
| rdata | output | 8 | Read result, registered at the read edge |
| busy | output | 1 | Internal program or erase running |

## Verification
A state machine stuck in the wrong step shows up at the next keyed write. Either busy fails to rise one clock later, or it rises where no operation was requested. A later read-back of the target byte then differs from the AND-or-FFh model. A wrong identification flag is visible on the very next read of address 0, because BFh and array data differ. A wrong operation-kind register or toggle state corrupts the first busy read, and a miscounted timer moves the falling edge of busy by the counted number of clocks.

// File: rtl/nor_cmd_pkg.sv
package nor_cmd_pkg;

    localparam int CMP_W = 15;

    localparam logic [CMP_W-1:0] ADR_KEY_A = 15'h555;
    localparam logic [CMP_W-1:0] ADR_KEY_B = 15'h2AA;

    localparam logic [7:0] K_UNLOCK_1 = 8'hAA;
    localparam logic [7:0] K_UNLOCK_2 = 8'h55;
    localparam logic [7:0] K_PROGRAM  = 8'hA0;
    localparam logic [7:0] K_ERASE    = 8'h80;
    localparam logic [7:0] K_SECTOR   = 8'h20;
    localparam logic [7:0] K_CHIP     = 8'h10;
    localparam logic [7:0] K_ID_ENTER = 8'h90;
    localparam logic [7:0] K_ID_LEAVE = 8'hF0;
    localparam logic [7:0] MFR_CODE   = 8'hBF;

    typedef enum logic [2:0] {
        S_IDLE,
        S_KEY1,
        S_KEY2,
        S_PROG_ARM,
        S_ERA_ARM,
        S_ERA_KEY1,
        S_ERA_KEY2,
        S_BUSY
    } seq_state_e;

endpackage

// File: rtl/nor_op_timer.sv
module nor_op_timer #(
    parameter int PROG_CYC = 20,
    parameter int SECT_CYC = 60,
    parameter int CHIP_CYC = 120
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go_prog,
    input  logic go_sect,
    input  logic go_chip,
    output logic done
);
    localparam int CNT_W = $clog2(CHIP_CYC + 1);

    logic [CNT_W-1:0] remain;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (go_prog) begin
            remain <= CNT_W'(PROG_CYC);
        end else if (go_sect) begin
            remain <= CNT_W'(SECT_CYC);
        end else if (go_chip) begin
            remain <= CNT_W'(CHIP_CYC);
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    assign done = (remain == CNT_W'(1));

endmodule

// File: rtl/nor_cell_array.sv
module nor_cell_array #(
    parameter int ARRAY_AW = 9,
    parameter int SECT_AW  = 7
) (
    input  logic                clk,
    input  logic [ARRAY_AW-1:0] idx,
    input  logic [7:0]          wdata,
    input  logic                go_prog,
    input  logic                go_sect,
    input  logic                go_chip,
    output logic [7:0]          rd_byte
);
    localparam int DEPTH = 1 << ARRAY_AW;
    localparam int SEC_W = ARRAY_AW - SECT_AW;

    logic [7:0] cells [DEPTH];
    logic [SEC_W-1:0] hit_sec;

    assign hit_sec = idx[ARRAY_AW-1:SECT_AW];

    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
        localparam logic [SEC_W-1:0]    MY_SEC = SEC_W'(g >> SECT_AW);
        localparam logic [ARRAY_AW-1:0] MY_IDX = ARRAY_AW'(g);

        always_ff @(posedge clk) begin
            if (go_chip || (go_sect && hit_sec == MY_SEC)) begin
                cells[g] <= 8'hFF;
            end else if (go_prog && idx == MY_IDX) begin
                cells[g] <= cells[g] & wdata;
            end
        end
    end

    assign rd_byte = cells[idx];

endmodule

// File: rtl/nor_cmd_fsm.sv
module nor_cmd_fsm
    import nor_cmd_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    input  logic              tmr_done,
    output logic              busy,
    output logic              id_mode,
    output logic              go_prog,
    output logic              go_sect,
    output logic              go_chip
);
    seq_state_e cur, nxt;
    logic at_a, at_b, id_set, id_clr;
    logic unused_hi;

    assign unused_hi = ^addr[ADDR_W-1:CMP_W];
    assign at_a = wr_en && (addr[CMP_W-1:0] == ADR_KEY_A);
    assign at_b = wr_en && (addr[CMP_W-1:0] == ADR_KEY_B);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur     <= S_IDLE;
            id_mode <= 1'b0;
        end else begin
            cur <= nxt;
            if (id_set)      id_mode <= 1'b1;
            else if (id_clr) id_mode <= 1'b0;
        end
    end

    always_comb begin
        nxt = cur;
        unique case (cur)
            S_IDLE: begin
                if (at_a && wdata == K_UNLOCK_1) nxt = S_KEY1;
            end
            S_KEY1: begin
                if (wr_en) nxt = (at_b && wdata == K_UNLOCK_2) ? S_KEY2 : S_IDLE;
            end
            S_KEY2: begin
                if (at_a && wdata == K_PROGRAM)    nxt = S_PROG_ARM;
                else if (at_a && wdata == K_ERASE) nxt = S_ERA_ARM;
                else if (wr_en)                    nxt = S_IDLE;
            end
            S_PROG_ARM: begin
                if (wr_en) nxt = S_BUSY;
            end
            S_ERA_ARM: begin
                if (wr_en) nxt = (at_a && wdata == K_UNLOCK_1) ? S_ERA_KEY1 : S_IDLE;
            end
            S_ERA_KEY1: begin
                if (wr_en) nxt = (at_b && wdata == K_UNLOCK_2) ? S_ERA_KEY2 : S_IDLE;
            end
            S_ERA_KEY2: begin
                if (wr_en && wdata == K_SECTOR)    nxt = S_BUSY;
                else if (at_a && wdata == K_CHIP)  nxt = S_BUSY;
                else if (wr_en)                    nxt = S_IDLE;
            end
            S_BUSY: begin
                if (tmr_done) nxt = S_IDLE;
            end
            default: nxt = S_IDLE;
        endcase
    end

    always_comb begin
        busy    = (cur == S_BUSY);
        go_prog = (cur == S_PROG_ARM) && wr_en;
        go_sect = (cur == S_ERA_KEY2) && wr_en && (wdata == K_SECTOR);
        go_chip = (cur == S_ERA_KEY2) && at_a && (wdata == K_CHIP);
        id_set  = (cur == S_KEY2) && at_a && (wdata == K_ID_ENTER);
        id_clr  = ((cur == S_IDLE) && wr_en && (wdata == K_ID_LEAVE))
               || ((cur == S_KEY2) && at_a && (wdata == K_ID_LEAVE));
    end

endmodule

// File: rtl/nor_read_path.sv
module nor_read_path
    import nor_cmd_pkg::*;
#(
    parameter logic [7:0] DEV_CODE = 8'hC3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rd_en,
    input  logic       a0,
    input  logic       busy,
    input  logic       id_mode,
    input  logic [7:0] arr_byte,
    input  logic       op_start,
    input  logic       op_prog,
    input  logic       prog_msb,
    output logic [7:0] rdata,
    output logic       op_erase
);
    logic tog;
    logic poll_bit;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata    <= 8'h00;
            tog      <= 1'b0;
            poll_bit <= 1'b0;
            op_erase <= 1'b0;
        end else begin
            if (op_start) begin
                tog      <= 1'b0;
                op_erase <= !op_prog;
                poll_bit <= op_prog ? !prog_msb : 1'b0;
            end
            if (rd_en) begin
                if (busy) begin
                    rdata <= {poll_bit, !tog, 6'b000000};
                    tog   <= !tog;
                end else if (id_mode) begin
                    rdata <= a0 ? DEV_CODE : MFR_CODE;
                end else begin
                    rdata <= arr_byte;
                end
            end
        end
    end

endmodule

// File: rtl/nor_cmd_engine.sv
module nor_cmd_engine
    import nor_cmd_pkg::*;
#(
    parameter int         ADDR_W   = 16,
    parameter int         ARRAY_AW = 9,
    parameter int         PROG_CYC = 20,
    parameter int         SECT_CYC = 60,
    parameter int         CHIP_CYC = 120,
    parameter logic [7:0] DEV_CODE = 8'hC3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    output logic              busy
);
    localparam int SECT_AW = 7;

    logic tmr_done, id_mode, op_erase;
    logic go_prog, go_sect, go_chip;
    logic [7:0] arr_byte;

    nor_cmd_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .addr    (addr),
        .wdata   (wdata),
        .tmr_done(tmr_done),
        .busy    (busy),
        .id_mode (id_mode),
        .go_prog (go_prog),
        .go_sect (go_sect),
        .go_chip (go_chip)
    );

    nor_op_timer #(
        .PROG_CYC(PROG_CYC),
        .SECT_CYC(SECT_CYC),
        .CHIP_CYC(CHIP_CYC)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .go_prog(go_prog),
        .go_sect(go_sect),
        .go_chip(go_chip),
        .done   (tmr_done)
    );

    nor_cell_array #(.ARRAY_AW(ARRAY_AW), .SECT_AW(SECT_AW)) u_array (
        .clk    (clk),
        .idx    (addr[ARRAY_AW-1:0]),
        .wdata  (wdata),
        .go_prog(go_prog),
        .go_sect(go_sect),
        .go_chip(go_chip),
        .rd_byte(arr_byte)
    );

    nor_read_path #(.DEV_CODE(DEV_CODE)) u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (rd_en),
        .a0      (addr[0]),
        .busy    (busy),
        .id_mode (id_mode),
        .arr_byte(arr_byte),
        .op_start(go_prog | go_sect | go_chip),
        .op_prog (go_prog),
        .prog_msb(wdata[7]),
        .rdata   (rdata),
        .op_erase(op_erase)
    );

endmodule

// File: rtl/nor_cmd_engine_chk.sv
module nor_cmd_engine_chk
    import nor_cmd_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic       rd_en,
    input logic       a0,
    input logic       busy,
    input logic       id_mode,
    input logic       op_erase,
    input logic [7:0] rdata
);

    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (!busy && !id_mode && rdata == 8'h00));

    assert_busy_from_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(wr_en));

    assert_busy_holds_id_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_en) |=> $stable(id_mode));

    assert_erase_poll_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && rd_en && op_erase) |=> (rdata[7] == 1'b0 && rdata[5:0] == 6'b000000));

    assert_toggle_flip_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && rd_en && $past(busy && rd_en)) |=> (rdata[6] != $past(rdata[6])));

    assert_mfr_code_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && id_mode && rd_en && !a0) |=> (rdata == MFR_CODE));

    assert_id_exit_by_write_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(id_mode) |-> ($past(wr_en) || !$past(rst_n)));

    assert_rdata_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));

endmodule

bind nor_cmd_engine nor_cmd_engine_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .a0      (addr[0]),
    .busy    (busy),
    .id_mode (id_mode),
    .op_erase(op_erase),
    .rdata   (rdata)
);

// File: tb/nor_cmd_engine_tb.sv
module nor_cmd_engine_tb;
    localparam int CLK_P    = 10;
    localparam int AW       = 16;
    localparam int AAW      = 9;
    localparam int DEPTH    = 1 << AAW;
    localparam int PROG     = 20;
    localparam int SECT     = 60;
    localparam int CHIP     = 120;
    localparam logic [7:0] DEV = 8'hC3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [7:0]    wdata = '0;
    logic [7:0]    rdata;
    logic          busy;

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] mdl [DEPTH];

    nor_cmd_engine #(
        .ADDR_W(AW), .ARRAY_AW(AAW), .PROG_CYC(PROG),
        .SECT_CYC(SECT), .CHIP_CYC(CHIP), .DEV_CODE(DEV)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .busy(busy)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [7:0] d);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic wait_done(output int c);
        c = 0;
        while (busy && c < 10000) begin
            @(negedge clk);
            c++;
        end
    endtask

    task automatic unlock(input logic [AW-1:0] hi);
        wr(hi | 16'h0555, 8'hAA);
        wr(hi | 16'h02AA, 8'h55);
    endtask

    task automatic prog(input logic [AW-1:0] a, input logic [7:0] d);
        unlock(16'h0000);
        wr(16'h0555, 8'hA0);
        wr(a, d);
        mdl[a[AAW-1:0]] = mdl[a[AAW-1:0]] & d;
    endtask

    task automatic erase_pre();
        unlock(16'h0000);
        wr(16'h0555, 8'h80);
        unlock(16'h0000);
    endtask

    task automatic sect_erase(input logic [AW-1:0] a);
        erase_pre();
        wr(a, 8'h20);
        for (int i = 0; i < DEPTH; i++)
            if ((i >> 7) == int'(a[AAW-1:7])) mdl[i] = 8'hFF;
    endtask

    task automatic chip_erase();
        erase_pre();
        wr(16'h0555, 8'h10);
        for (int i = 0; i < DEPTH; i++) mdl[i] = 8'hFF;
    endtask

    function automatic logic [7:0] exp_byte(input logic [AW-1:0] a);
        return mdl[a[AAW-1:0]];
    endfunction

    task automatic rd_chk(input logic [AW-1:0] a, input logic [7:0] e, input string tag);
        logic [7:0] v;
        rd(a, v);
        chk(v === e, tag, int'(v), int'(e));
    endtask

    initial begin
        #(CLK_P * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [7:0] v;
        int c;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk(busy === 1'b0, "R1 busy after reset", int'(busy), 0);
        chk(rdata === 8'h00, "R1 rdata after reset", int'(rdata), 0);

        // whole-array erase with status polling
        chip_erase();
        rd(16'h0000, v); chk(v === 8'h40, "R8 R9 erase poll first", int'(v), 'h40);
        rd(16'h0001, v); chk(v === 8'h00, "R9 erase poll second", int'(v), 'h00);
        wait_done(c); chk(c == CHIP - 2, "R10 chip erase length", c, CHIP - 2);
        rd_chk(16'h01FF, 8'hFF, "R5 chip erase top byte");
        rd_chk(16'h0000, 8'hFF, "R5 chip erase bottom byte");

        // byte program and AND semantics
        prog(16'h0012, 8'hA5);
        rd(16'h0000, v); chk(v === 8'h40, "R8 program poll msb1", int'(v), 'h40);
        rd(16'h0000, v); chk(v === 8'h00, "R9 program toggle", int'(v), 'h00);
        wait_done(c); chk(c == PROG - 2, "R10 program length", c, PROG - 2);
        rd_chk(16'h0012, 8'hA5, "R3 program result");
        prog(16'h0012, 8'h5A);
        rd(16'h0000, v); chk(v === 8'hC0, "R8 program poll msb0", int'(v), 'hC0);
        wait_done(c);
        rd_chk(16'h0012, 8'h00, "R3 program AND");

        // upper address bits ignored during key match
        unlock(16'h8000);
        wr(16'h8555, 8'hA0);
        wr(16'h8034, 8'h3C);
        mdl[9'h034] = 8'h3C;
        wait_done(c); chk(c == PROG, "R10 program length no reads", c, PROG);
        rd_chk(16'h0034, 8'h3C, "R2 upper bits ignored");

        // sector erase keeps neighbours
        prog(16'h00C5, 8'h11); wait_done(c);
        prog(16'h007F, 8'h22); wait_done(c);
        prog(16'h0100, 8'h33); wait_done(c);
        sect_erase(16'h00A0);
        wait_done(c); chk(c == SECT, "R10 sector erase length", c, SECT);
        rd_chk(16'h00C5, 8'hFF, "R4 sector byte erased");
        rd_chk(16'h007F, 8'h22, "R4 lower sector kept");
        rd_chk(16'h0100, 8'h33, "R4 upper sector kept");

        // aborts
        unlock(16'h0000);
        wr(16'h0555, 8'h33);
        wr(16'h0555, 8'hA0);
        wr(16'h0040, 8'h00);
        chk(busy === 1'b0, "R6 abort no busy", int'(busy), 0);
        rd_chk(16'h0040, 8'hFF, "R6 abort array kept");
        wr(16'h0555, 8'hAA);
        wr(16'h02AA, 8'h12);
        wr(16'h02AA, 8'h55);
        wr(16'h0555, 8'hA0);
        wr(16'h0041, 8'h00);
        rd_chk(16'h0041, 8'hFF, "R6 restart required");
        erase_pre();
        wr(16'h0444, 8'h10);
        chk(busy === 1'b0, "R6 chip code wrong address", int'(busy), 0);
        rd_chk(16'h0034, 8'h3C, "R6 no erase after abort");

        // writes while busy ignored
        prog(16'h0050, 8'h0F);
        unlock(16'h0000);
        wr(16'h0555, 8'hA0);
        wr(16'h0051, 8'h00);
        unlock(16'h0000);
        wr(16'h0555, 8'h90);
        wait_done(c);
        rd_chk(16'h0051, 8'hFF, "R7 program ignored while busy");
        rd_chk(16'h0000, 8'hFF, "R7 id entry ignored while busy");
        rd_chk(16'h0050, 8'h0F, "R3 program before busy");

        // identification mode
        unlock(16'h0000);
        wr(16'h0555, 8'h90);
        rd_chk(16'h0000, 8'hBF, "R11 maker code");
        rd_chk(16'h8001, DEV, "R11 device code");
        rd_chk(16'h0203, DEV, "R11 device code odd address");
        wr(16'h1234, 8'hF0);
        rd_chk(16'h0012, 8'h00, "R12 single write exit");
        unlock(16'h0000);
        wr(16'h0555, 8'h90);
        rd_chk(16'h0000, 8'hBF, "R11 reentry");
        unlock(16'h0000);
        wr(16'h0555, 8'hF0);
        rd_chk(16'h0000, 8'hFF, "R12 keyed exit");

        // exit ignored while busy
        unlock(16'h0000);
        wr(16'h0555, 8'h90);
        prog(16'h0060, 8'h80);
        wr(16'h0000, 8'hF0);
        wait_done(c);
        rd_chk(16'h0000, 8'hBF, "R7 exit ignored while busy");
        wr(16'h0000, 8'hF0);
        rd_chk(16'h0060, 8'h80, "R3 program in id mode");

        // reset cancels operation, id mode and sequence
        unlock(16'h0000);
        wr(16'h0555, 8'h90);
        chip_erase();
        repeat (3) @(negedge clk);
        chk(busy === 1'b1, "R10 busy mid erase", int'(busy), 1);
        rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
        chk(busy === 1'b0, "R1 reset stops busy", int'(busy), 0);
        rd_chk(16'h0000, 8'hFF, "R1 reset leaves id mode");
        unlock(16'h0000);
        rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
        wr(16'h0555, 8'hA0);
        wr(16'h0070, 8'h00);
        chk(busy === 1'b0, "R1 reset clears sequence", int'(busy), 0);
        rd_chk(16'h0070, 8'hFF, "R1 sequence array kept");

        // read data holds
        prog(16'h0012, 8'hFF); wait_done(c);
        rd(16'h0012, v);
        repeat (3) @(negedge clk);
        chk(rdata === v, "R13 hold while idle", int'(rdata), int'(v));
        wr(16'h1111, 8'h99);
        chk(rdata === v, "R13 hold across write", int'(rdata), int'(v));

        // constrained random mix
        for (int it = 0; it < 40; it++) begin
            logic [AW-1:0] ra;
            logic [7:0] rdv;
            int sel;
            sel = int'($urandom % 5);
            ra = AW'($urandom);
            rdv = 8'($urandom);
            if (sel <= 1) begin
                prog(ra, rdv); wait_done(c);
                chk(c == PROG, "R10 random program length", c, PROG);
                rd_chk(ra, exp_byte(ra), "R3 random program");
            end else if (sel == 2) begin
                rd_chk(ra, exp_byte(ra), "R3 random read");
            end else if (sel == 3) begin
                if (rdv == 8'hAA) rdv = 8'h00;
                wr(ra, rdv);
                chk(busy === 1'b0, "R6 random stray write", int'(busy), 0);
                rd_chk(ra, exp_byte(ra), "R6 stray write no change");
            end else begin
                sect_erase(ra); wait_done(c);
                rd_chk(ra, 8'hFF, "R4 random sector erase");
            end
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule